// File: doc/BRIEF.md
# Clocked Controller for a 64K x 1 Asynchronous Static RAM

This block sits between a clocked host and an external asynchronous static RAM that stores 65,536 one-bit words, with separate data-in and data-out pins, an active-low chip select and an active-low write strobe. The host hands over one request at a time on a valid/ready handshake: a 16-bit address, a write flag and one write data bit. For a read the controller returns one data bit together with a single-cycle valid pulse.

The RAM has no clock, so every access is built from registered strobes whose phase lengths are counted in clock cycles. Each phase length comes from a nanosecond limit divided by the clock period, rounded up, with a floor of one cycle. Writes open the chip select first, pulse the write strobe inside that window, and close the write on the rising edge of the write strobe. The address and write data stay unchanged for the whole access. Between requests the chip select is released, so the RAM drops into its deselected low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and just after reset, chip select and write strobe are both high (inactive), `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access finishes. `req_valid` pulses raised while busy start no access. The RAM address and data-in pins carry the accepted values, unchanged, for the whole access.
- R3: In a write, the write strobe falls after chip select has been low for the setup phase. It stays low for the pulse phase, and then rises while chip select is still low. Chip select rises after the recovery phase.
- R4: The write strobe is never low while chip select is high, and it stays high for the whole of a read.
- R5: For a read accepted at edge k, `rsp_valid` is 1 for exactly one cycle after edge k + access phase + 1, and `rsp_rdata` holds the RAM data-out value sampled at that edge.
- R6: Chip select is high whenever the controller is idle, and it is released on the same edge that ends an access.
- R7: A bit written to an address is returned by a later read of that address, including the lowest (0x0000) and highest (0xFFFF) addresses.
- R8: Each phase count is the ceiling of its nanosecond limit over the clock period, at least 1. The pulse phase covers both the strobe width and the data setup limit. With the defaults (10 ns clock; 0/12/10/15/15 ns for address setup, pulse width, data setup, cycle time and access time), the counts are setup 1, pulse 2, recovery 1 and access 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 1 | Read data bit |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_addr | output | 16 | RAM address pins |
| sram_din | output | 1 | RAM data-in pin |
| sram_dout | input | 1 | RAM data-out pin |

## Verification
With the default counts, the strobes of a write accepted at edge k change as follows. The write strobe is low after edges k+1 and k+2 and high again after edge k+3. Chip select rises after edge k+4, which is also when `req_ready` returns. For a read accepted at edge k, chip select stays low through edge k+2. At edge k+3 the data bit is captured and `rsp_valid` rises. The bench drives inputs on falling edges and, after each accept, samples every output on the falling edge of each following cycle. It compares them with a per-cycle table of expected levels, so an early or late strobe is caught in the exact cycle where it differs.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the asynchronous RAM controller.
// Assumes all timing limits are given in whole nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctrl_state_e;

    // Rounds a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned lim_ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (lim_ns + period_ns - 1) / period_ns;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_cyc(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one strobe phase.
// Loaded with (length - 1) on the edge that starts a phase; 'expired' is high
// in the last cycle of the phase. Assumes load values fit in CNT_W bits.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Phase is over when the count has reached zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
// Access sequencer: walks a read or write through its timed phases and
// drives the registered chip select and write strobe.
// Assumes every *_CYC parameter is at least 1 and fits in CNT_W bits.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int SU_CYC = 1,
    parameter int PW_CYC = 2,
    parameter int RC_CYC = 1,
    parameter int RD_CYC = 2,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_done,
    output logic             ready,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             capture,
    output logic             ce_n,
    output logic             we_n
);
    localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] PW_LD = CNT_W'(PW_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);

    ctrl_state_e state_q, state_d;
    logic        ce_n_d, we_n_d;

    // Handshake and capture strobes come straight from the state.
    always_comb begin
        ready   = (state_q == ST_IDLE);
        accept  = ready && req_valid;
        capture = (state_q == ST_RD_CAPTURE);
    end

    // Next state, next strobe levels and timer reloads.
    always_comb begin
        state_d    = state_q;
        ce_n_d     = ce_n;
        we_n_d     = we_n;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    ce_n_d     = 1'b0;
                    timer_load = 1'b1;
                    if (req_write) begin
                        state_d   = ST_WR_SETUP;
                        timer_val = SU_LD;
                    end else begin
                        state_d   = ST_RD_ACCESS;
                        timer_val = RD_LD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (phase_done) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                ce_n_d  = 1'b1;
                state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (phase_done) begin
                    we_n_d     = 1'b0;
                    timer_load = 1'b1;
                    timer_val  = PW_LD;
                    state_d    = ST_WR_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (phase_done) begin
                    we_n_d     = 1'b1;
                    timer_load = 1'b1;
                    timer_val  = RC_LD;
                    state_d    = ST_WR_RECOVER;
                end
            end
            ST_WR_RECOVER: begin
                if (phase_done) begin
                    ce_n_d  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                ce_n_d  = 1'b1;
                we_n_d  = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and strobe registers; strobes are inactive after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
        end else begin
            state_q <= state_d;
            ce_n    <= ce_n_d;
            we_n    <= we_n_d;
        end
    end

endmodule

// File: rtl/sram_ctrl_datapath.sv
// Holds the address and write bit for the RAM pins during an access, and
// registers the read bit with its one-cycle valid pulse.
// Assumes 'accept' only rises while no access is running.
module sram_ctrl_datapath #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    input  logic              capture,
    input  logic              ram_dout,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_din,
    output logic              rsp_valid,
    output logic              rsp_rdata
);
    // Latch the request address and data; they then hold until the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr <= '0;
            ram_din  <= 1'b0;
        end else if (accept) begin
            ram_addr <= req_addr;
            ram_din  <= req_wdata;
        end
    end

    // Sample the RAM output at the end of a read and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= ram_dout;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top level: clocked valid/ready host port to a 64K x 1 asynchronous RAM.
// Phase lengths are derived from nanosecond limits and the clock period at
// elaboration. Assumes the RAM pins are registered here and used directly.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int CLK_NS       = 10,
    parameter int T_ADDR_SU_NS = 0,
    parameter int T_WE_PW_NS   = 12,
    parameter int T_DATA_SU_NS = 10,
    parameter int T_CYCLE_NS   = 15,
    parameter int T_ACCESS_NS  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rsp_valid,
    output logic              rsp_rdata,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_din,
    input  logic              sram_dout
);
    localparam int SU_CYC  = ns_to_cycles(T_ADDR_SU_NS, CLK_NS);
    localparam int PW_CYC  = max_cyc(ns_to_cycles(T_WE_PW_NS, CLK_NS),
                                     ns_to_cycles(T_DATA_SU_NS, CLK_NS));
    localparam int WC_CYC  = ns_to_cycles(T_CYCLE_NS, CLK_NS);
    localparam int RC_CYC  = (WC_CYC > SU_CYC + PW_CYC) ? (WC_CYC - SU_CYC - PW_CYC) : 1;
    localparam int RD_CYC  = ns_to_cycles(T_ACCESS_NS, CLK_NS);
    localparam int MAX_CYC = max_cyc(max_cyc(SU_CYC, PW_CYC), max_cyc(RC_CYC, RD_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             accept, capture, phase_done, timer_load;
    logic [CNT_W-1:0] timer_val;

    sram_ctrl_fsm #(
        .SU_CYC(SU_CYC), .PW_CYC(PW_CYC), .RC_CYC(RC_CYC),
        .RD_CYC(RD_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .phase_done(phase_done), .ready(req_ready), .accept(accept),
        .timer_load(timer_load), .timer_val(timer_val), .capture(capture),
        .ce_n(sram_ce_n), .we_n(sram_we_n)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load),
        .load_val(timer_val), .expired(phase_done)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .capture(capture), .ram_dout(sram_dout),
        .ram_addr(sram_addr), .ram_din(sram_din),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
// Protocol checker for the RAM-side strobes; bound into sram_async_ctrl.
// Assumes SU_CYC and PW_CYC match the controller's derived phase counts.
module sram_ctrl_checker #(
    parameter int ADDR_W = 16,
    parameter int SU_CYC = 1,
    parameter int PW_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_din,
    input logic              ready,
    input logic              rsp_valid
);
    logic       past_ok;
    logic [7:0] we_low_cnt, ce_lead_cnt;

    // Marks that at least one cycle has passed since reset.
    always_ff @(posedge clk) past_ok <= rst_n;

    // Counts cycles of write strobe low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || we_n) we_low_cnt <= '0;
        else if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 1'b1;
    end

    // Counts cycles of chip select low before the write strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_n) ce_lead_cnt <= '0;
        else if (we_n && ce_lead_cnt != 8'hFF) ce_lead_cnt <= ce_lead_cnt + 1'b1;
    end

    a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> !ready);

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !ce_n && $past(!ce_n)) |-> $stable(ram_addr));

    a_r3_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !ce_n && $past(!ce_n)) |-> $stable(ram_din));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(we_n)) |-> (we_low_cnt >= PW_CYC));

    a_r3_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(we_n)) |-> (ce_lead_cnt >= SU_CYC));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .ADDR_W(ADDR_W), .SU_CYC(SU_CYC), .PW_CYC(PW_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(sram_ce_n), .we_n(sram_we_n),
    .ram_addr(sram_addr), .ram_din(sram_din), .ready(req_ready),
    .rsp_valid(rsp_valid)
);

// File: tb/tb_sram_async_ctrl.sv
// Directed bench: one task per scenario, each checking its own cycles.
module tb_sram_async_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_rdata;
    logic        sram_ce_n, sram_we_n, sram_din, sram_dout;
    logic [15:0] sram_addr;
    logic        ram_mem [256];
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_din(sram_din),
        .sram_dout(sram_dout)
    );

    // Behavioural RAM stand-in (low 8 address bits): write ends on strobe rise.
    always @(posedge sram_we_n) if (sram_ce_n === 1'b0) ram_mem[sram_addr[7:0]] = sram_din;
    assign sram_dout = (!sram_ce_n && sram_we_n) ? ram_mem[sram_addr[7:0]] : 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Present one request on a falling edge; it is taken on the next rising edge.
    task automatic issue(input logic wr, input logic [15:0] a, input logic d);
        @(negedge clk);
        chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ce_n in reset", {31'd0, sram_ce_n}, 32'd1);
        chk("R1 we_n in reset", {31'd0, sram_we_n}, 32'd1);
        chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    endtask

    // Write: per-cycle expected {ce_n, we_n} = 01,00,00,01,11 (R3, R8).
    task automatic t_write(input logic [15:0] a, input logic d);
        logic [1:0] exp_s [5] = '{2'b01, 2'b00, 2'b00, 2'b01, 2'b11};
        issue(1'b1, a, d);
        for (int i = 0; i < 5; i++) begin
            if (i > 0) @(negedge clk);
            chk("R3 write strobes", {30'd0, sram_ce_n, sram_we_n}, {30'd0, exp_s[i]});
            if (i < 4) begin
                chk("R2 addr held", {16'd0, sram_addr}, {16'd0, a});
                chk("R2 din held", {31'd0, sram_din}, {31'd0, d});
                chk("R2 busy", {31'd0, req_ready}, 32'd0);
            end else begin
                chk("R6 ce released idle", {31'd0, sram_ce_n}, 32'd1);
            end
        end
    endtask

    // Read: ce low for 3 cycles, rsp_valid in cycle 4 only (R5, R4).
    task automatic t_read(input logic [15:0] a, input logic exp);
        issue(1'b0, a, 1'b0);
        for (int i = 0; i < 5; i++) begin
            if (i > 0) @(negedge clk);
            chk("R4 we high in read", {31'd0, sram_we_n}, 32'd1);
            chk("R5 rsp_valid timing", {31'd0, rsp_valid}, (i == 3) ? 32'd1 : 32'd0);
            chk("R6 ce timing", {31'd0, sram_ce_n}, (i >= 3) ? 32'd1 : 32'd0);
            if (i < 3) chk("R2 read addr", {16'd0, sram_addr}, {16'd0, a});
            if (i == 3) chk("R7 read data", {31'd0, rsp_rdata}, {31'd0, exp});
        end
    endtask

    // A valid pulse while busy must start nothing once the write ends (R2).
    task automatic t_busy_ignore;
        issue(1'b1, 16'h0042, 1'b1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0099;
        @(negedge clk);
        chk("R2 addr ignores busy request", {16'd0, sram_addr}, 32'h0042);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 idle after busy request", {31'd0, sram_ce_n}, 32'd1);
        @(negedge clk);
        chk("R2 no extra access", {30'd0, sram_ce_n, rsp_valid}, 32'd2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram_mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write(16'h0000, 1'b1);
        t_write(16'hFFFF, 1'b1);
        t_write(16'h1234, 1'b0);
        t_read(16'h0000, 1'b1);
        t_read(16'hFFFF, 1'b1);
        t_read(16'h1234, 1'b0);
        t_write(16'hFFFF, 1'b0);
        t_read(16'hFFFF, 1'b0);
        t_busy_ignore;
        t_read(16'h0042, 1'b1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule